// File: doc/BRIEF.md
# TDM Slot-Masked Serial Transmitter

This block sends fixed-length words onto a shared time-division serial line. A frame holds `N` time slots of `W` bits each. A per-slot enable mask decides which slots this transmitter owns. In an owned slot the block drives the line. In any other slot it releases the line so that other devices can use it. The line is modelled as a data bit plus an output enable, and the pad logic outside turns the pair into a tri-state driver.

Software feeds the block through a single write beat. A beat either carries a new data word or marks a "silent" write, which keeps this transmitter off the line for its next owned slot. At the start of each owned slot the block raises a data-empty request, which can also drive an interrupt. If software has not written anything since the previous owned slot began, the block reports an underrun and sends the previous word again.

The bit clock and the frame sync come in as plain levels. Both are sampled in the system clock domain, and every decision is taken on a detected rising edge of the bit clock.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset `txd_oe`, `tde`, `tue` and `irq` are 0. `txd_oe` stays 0 until the first rising edge of `fsync` has been seen at a bit-clock rise.
- R2: A rising `fsync`, sampled at a `bclk` rise, makes that bit the first bit of slot 0. Every `W` bits after that begins the next slot. After slot `N-1` the count wraps to slot 0 with no new sync, and a sync edge in the middle of a frame restarts at slot 0.
- R3: A slot whose bit in `slot_mask` is 0 (bit i governs slot i) keeps `txd_oe` low for the whole slot and does not set `tde`.
- R4: In an enabled slot that was prepared with a data write, the data register is loaded and sent MSB first, one bit for each `bclk` rise. `txd_oe` stays high for all `W` bits.
- R5: `tde` is set at the first bit of every enabled slot and is cleared by any accepted write, whether data or silent. `irq` equals `tde` while `irq_en` is 1 and stays 0 while `irq_en` is 0.
- R6: If no write was accepted between the start of the previous enabled slot and the start of this one, `tue` is set. The block then drives the line and sends the stored data word again.
- R7: If the last write before an enabled slot was a silent write, `txd_oe` stays low for that slot and `tue` is not set.
- R8: `tue` is cleared only by a data write that follows a `stat_rd` pulse. A data write with no read before it leaves `tue` set.
- R9: `wr_ready` is always 1. A later data write replaces an earlier one, and a data write after a silent write cancels the silent write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock (level, sampled) |
| fsync | input | 1 | Frame sync, one word long, active high |
| slot_mask | input | N | Slot enable mask, bit i governs slot i |
| irq_en | input | 1 | Interrupt enable for the data-empty request |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready (always 1) |
| wr_silent | input | 1 | Beat is a silent write; `wr_data` is ignored |
| wr_data | input | W | Transmit word |
| stat_rd | input | 1 | Status-read pulse that arms the underrun clear |
| txd | output | 1 | Serial data (0 while not driven) |
| txd_oe | output | 1 | Output enable for the serial line |
| tde | output | 1 | Transmit data-empty flag |
| irq | output | 1 | Data-empty interrupt |
| tue | output | 1 | Transmit underrun flag |

## Verification
The bench uses five slots with slots 0 and 3 enabled and runs four kinds of write pattern. The first pattern writes a fresh word before every owned slot, which shows that the mask gates the line and that words go out MSB first. The second skips a write, which separates a true underrun resend from a normal send. The third places a silent write last, and the fourth places a silent write followed by a data write, which shows whether silence applies only to the most recent write. Frames are also run with the sync pulse left out and with it moved into the middle of a frame, which separates wrap-by-count from restart-on-sync.

// File: rtl/tdmtx_pkg.sv
package tdmtx_pkg;
  // what the shifter does at a boundary into an enabled slot
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_SEND = 2'd1,
    ACT_HUSH = 2'd2
  } tx_act_e;
endpackage

// File: rtl/tdmtx_timing.sv
module tdmtx_timing #(
  parameter int W  = 8,
  parameter int N  = 5,
  parameter int BW = (W > 1) ? $clog2(W) : 1,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          fsync,
  output logic          bit_rise,
  output logic          word_bnd,
  output logic [SW-1:0] nxt_slot,
  output logic          started
);
  localparam logic [BW-1:0] LAST_BIT  = BW'(W - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(N - 1);

  logic          bclk_q, bclk_q2, fs_q, fs_last;
  logic [BW-1:0] bit_cnt;
  logic [SW-1:0] slot;
  logic          fs_edge, cnt_bnd;

  assign bit_rise = bclk_q & ~bclk_q2;
  assign fs_edge  = bit_rise & fs_q & ~fs_last;
  assign cnt_bnd  = bit_rise & started & (bit_cnt == LAST_BIT);
  assign word_bnd = fs_edge | cnt_bnd;
  assign nxt_slot = (fs_edge || slot == LAST_SLOT) ? '0 : slot + SW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      bclk_q2 <= 1'b0;
      fs_q    <= 1'b0;
      fs_last <= 1'b0;
      bit_cnt <= '0;
      slot    <= '0;
      started <= 1'b0;
    end else begin
      bclk_q  <= bclk;
      bclk_q2 <= bclk_q;
      fs_q    <= fsync;
      if (bit_rise) begin
        fs_last <= fs_q;
        if (word_bnd) begin
          bit_cnt <= '0;
          slot    <= nxt_slot;
          started <= 1'b1;
        end else if (started) begin
          bit_cnt <= bit_cnt + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tdmtx_regs.sv
module tdmtx_regs
  import tdmtx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic         wr_silent,
  input  logic [W-1:0] wr_data,
  input  logic         stat_rd,
  input  logic         bnd_en,
  output logic [W-1:0] dreg,
  output tx_act_e      act,
  output logic         tde,
  output logic         tue
);
  logic wr_dat, wr_sil, wr_seen, sil, rd_arm, under;

  assign wr_dat = wr_valid & ~wr_silent;
  assign wr_sil = wr_valid & wr_silent;
  assign under  = bnd_en & ~wr_seen;
  assign act    = (!wr_seen || !sil) ? ACT_SEND : ACT_HUSH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg    <= '0;
      wr_seen <= 1'b0;
      sil     <= 1'b0;
      tde     <= 1'b0;
      tue     <= 1'b0;
      rd_arm  <= 1'b0;
    end else begin
      if (wr_dat) dreg <= wr_data;
      // a write coinciding with a boundary counts for the following slot
      if (bnd_en) begin
        wr_seen <= wr_valid;
        sil     <= wr_sil;
      end else begin
        if (wr_valid) wr_seen <= 1'b1;
        if (wr_sil) sil <= 1'b1;
        else if (wr_dat) sil <= 1'b0;
      end
      if (bnd_en) tde <= 1'b1;
      else if (wr_valid) tde <= 1'b0;
      if (under) begin
        tue    <= 1'b1;
        rd_arm <= 1'b0;
      end else begin
        if (wr_dat && rd_arm) tue <= 1'b0;
        if (stat_rd) rd_arm <= 1'b1;
        else if (wr_dat) rd_arm <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdmtx_shift.sv
module tdmtx_shift
  import tdmtx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_rise,
  input  logic         word_bnd,
  input  logic         slot_on,
  input  tx_act_e      act,
  input  logic [W-1:0] dreg,
  output logic [W-1:0] shreg,
  output logic         txd,
  output logic         txd_oe
);
  assign txd = txd_oe & shreg[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      txd_oe <= 1'b0;
    end else if (word_bnd) begin
      if (slot_on && act == ACT_SEND) begin
        shreg  <= dreg;
        txd_oe <= 1'b1;
      end else begin
        txd_oe <= 1'b0;
      end
    end else if (bit_rise) begin
      shreg <= {shreg[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdmtx_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         fsync,
  input  logic [N-1:0] slot_mask,
  input  logic         irq_en,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic         wr_silent,
  input  logic [W-1:0] wr_data,
  input  logic         stat_rd,
  output logic         txd,
  output logic         txd_oe,
  output logic         tde,
  output logic         irq,
  output logic         tue
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  logic          bit_rise, word_bnd, started, slot_on, bnd_en;
  logic [SW-1:0] nxt_slot;
  logic [W-1:0]  dreg, shreg;
  tx_act_e       act;

  assign wr_ready = 1'b1;
  assign slot_on  = slot_mask[nxt_slot];
  assign bnd_en   = word_bnd & slot_on;
  assign irq      = tde & irq_en;

  tdmtx_timing #(.W(W), .N(N)) timing_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .bit_rise(bit_rise), .word_bnd(word_bnd), .nxt_slot(nxt_slot),
    .started(started)
  );

  tdmtx_regs #(.W(W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_silent(wr_silent),
    .wr_data(wr_data), .stat_rd(stat_rd), .bnd_en(bnd_en),
    .dreg(dreg), .act(act), .tde(tde), .tue(tue)
  );

  tdmtx_shift #(.W(W)) shift_i (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .word_bnd(word_bnd),
    .slot_on(slot_on), .act(act), .dreg(dreg), .shreg(shreg),
    .txd(txd), .txd_oe(txd_oe)
  );
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk #(
  parameter int W  = 8,
  parameter int N  = 5,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  slot_mask,
  input logic          wr_valid,
  input logic          wr_silent,
  input logic          txd,
  input logic          txd_oe,
  input logic          tde,
  input logic          tue,
  input logic          bit_rise,
  input logic          word_bnd,
  input logic [SW-1:0] nxt_slot,
  input logic          started,
  input logic [W-1:0]  shreg
);
  // R1
  no_drive_before_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !txd_oe);

  // R3
  masked_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_bnd && !slot_mask[nxt_slot]) |=> (!txd_oe && !$rose(tde)));

  // R4
  msb_first_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_oe && bit_rise && !word_bnd) |=> (txd == $past(shreg[W-2])));

  // R5
  tde_set_at_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tde) |-> $past(word_bnd && slot_mask[nxt_slot]));

  // R5
  tde_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tde) |-> $past(wr_valid));

  // R6
  tue_set_at_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tue) |-> $past(word_bnd));

  // R8
  tue_clear_by_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tue) |-> $past(wr_valid && !wr_silent));
endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(.W(W), .N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .slot_mask(slot_mask), .wr_valid(wr_valid),
  .wr_silent(wr_silent), .txd(txd), .txd_oe(txd_oe), .tde(tde), .tue(tue),
  .bit_rise(bit_rise), .word_bnd(word_bnd), .nxt_slot(nxt_slot),
  .started(started), .shreg(shreg)
);

// File: tb/tdm_slot_tx_tb_top.sv
`timescale 1ns/1ps
module tdm_slot_tx_tb_top;
  localparam int W = 8;
  localparam int N = 5;
  localparam logic [N-1:0] MASK = 5'b01001; // slots 0 and 3

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, irq_en = 1'b1;
  logic wr_valid = 1'b0, wr_silent = 1'b0, stat_rd = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic wr_ready, txd, txd_oe, tde, irq, tue;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tdm_slot_tx #(.W(W), .N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .slot_mask(MASK),
    .irq_en(irq_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_silent(wr_silent), .wr_data(wr_data), .stat_rd(stat_rd),
    .txd(txd), .txd_oe(txd_oe), .tde(tde), .irq(irq), .tue(tue)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [W-1:0] d, input logic silent);
    @(negedge clk);
    wr_valid = 1'b1; wr_silent = silent; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_silent = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  // run one slot of W bits, sampling each bit late in its low phase
  task automatic slot_run(input logic sync, input logic exp_oe,
                          input logic [W-1:0] exp_word, input string req);
    logic [W-1:0] word;
    logic oe_all, oe_any;
    word = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int b = 0; b < W; b++) begin
      @(negedge clk);
      fsync = sync;
      bclk  = 1'b1;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
      repeat (4) @(negedge clk);
      word   = {word[W-2:0], txd};
      oe_all = oe_all & txd_oe;
      oe_any = oe_any | txd_oe;
    end
    fsync = 1'b0;
    if (exp_oe) begin
      check({req, " oe held"}, 32'(oe_all), 32'd1);
      check({req, " word"}, 32'(word), 32'(exp_word));
    end else begin
      check({req, " oe low"}, 32'(oe_any), 32'd0);
    end
  endtask

  task automatic t_reset();
    check("R1 oe after reset", 32'(txd_oe), 32'd0);
    check("R1 tde after reset", 32'(tde), 32'd0);
    check("R1 tue after reset", 32'(tue), 32'd0);
    check("R1 irq after reset", 32'(irq), 32'd0);
    check("R9 ready", 32'(wr_ready), 32'd1);
    slot_run(1'b0, 1'b0, '0, "R1 no sync yet");
  endtask

  task automatic t_basic();
    write_word(8'hA5, 1'b0);
    slot_run(1'b1, 1'b1, 8'hA5, "R4 slot0");
    check("R5 tde at enabled slot", 32'(tde), 32'd1);
    check("R5 irq follows tde", 32'(irq), 32'd1);
    check("R6 no underrun", 32'(tue), 32'd0);
    write_word(8'h3C, 1'b0);
    check("R5 tde cleared by write", 32'(tde), 32'd0);
    slot_run(1'b0, 1'b0, '0, "R3 slot1");
    check("R3 masked slot no request", 32'(tde), 32'd0);
    slot_run(1'b0, 1'b0, '0, "R3 slot2");
    slot_run(1'b0, 1'b1, 8'h3C, "R4 slot3");
    check("R5 tde at slot3", 32'(tde), 32'd1);
    write_word(8'h96, 1'b0);
    slot_run(1'b0, 1'b0, '0, "R3 slot4");
  endtask

  task automatic t_wrap_underrun();
    slot_run(1'b0, 1'b1, 8'h96, "R2 wrap slot0");
    check("R6 tue clear before miss", 32'(tue), 32'd0);
    slot_run(1'b0, 1'b0, '0, "R2 slot1");
    slot_run(1'b0, 1'b0, '0, "R2 slot2");
    slot_run(1'b0, 1'b1, 8'h96, "R6 resend");
    check("R6 tue set", 32'(tue), 32'd1);
  endtask

  task automatic t_tue_clear();
    write_word(8'h11, 1'b0);
    check("R8 write without read keeps tue", 32'(tue), 32'd1);
    slot_run(1'b0, 1'b0, '0, "R3 slot4 b");
    read_status();
    write_word(8'h22, 1'b0);
    check("R8 read then write clears tue", 32'(tue), 32'd0);
    slot_run(1'b1, 1'b1, 8'h22, "R9 last write wins");
  endtask

  task automatic t_silent();
    write_word(8'hFF, 1'b1);
    check("R5 silent write clears tde", 32'(tde), 32'd0);
    slot_run(1'b0, 1'b0, '0, "R3 slot1 c");
    slot_run(1'b0, 1'b0, '0, "R3 slot2 c");
    slot_run(1'b0, 1'b0, '0, "R7 silent slot3");
    check("R7 no underrun on silent", 32'(tue), 32'd0);
    check("R5 tde set on silent slot", 32'(tde), 32'd1);
    write_word(8'h00, 1'b1);
    write_word(8'h5A, 1'b0);
    slot_run(1'b0, 1'b0, '0, "R3 slot4 c");
    slot_run(1'b1, 1'b1, 8'h5A, "R9 data cancels silent");
  endtask

  task automatic t_resync_irq();
    write_word(8'h77, 1'b0);
    slot_run(1'b0, 1'b0, '0, "R3 slot1 d");
    slot_run(1'b1, 1'b1, 8'h77, "R2 mid-frame sync restarts slot0");
    irq_en = 1'b0;
    slot_run(1'b0, 1'b0, '0, "R2 slot1 after resync");
    slot_run(1'b0, 1'b0, '0, "R2 slot2 after resync");
    slot_run(1'b0, 1'b1, 8'h77, "R6 resend after resync");
    check("R6 tue set again", 32'(tue), 32'd1);
    check("R5 tde set", 32'(tde), 32'd1);
    check("R5 irq masked by irq_en", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_wrap_underrun();
    t_tue_clear();
    t_silent();
    t_resync_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule